// File: doc/BRIEF.md
# Banked serial-port register decoder

This block is the processor-facing register file of a classic 16550-style serial controller. A host reaches it through a single-transfer bus slave port with a 3-bit register offset and 8-bit data. The block holds the line control, interrupt enable, modem control and 16-bit baud divisor registers. It returns the receive character, interrupt identification, line status and modem status, which arrive as plain inputs from the datapath around it.

Offsets 0 and 1 are banked. The top bit of the line control register picks which bank they reach. With that bit clear they reach the character data path and the interrupt enable register. With it set they reach the two bytes of the divisor. Offset 2 is split by direction: a read returns interrupt identification, and a write becomes a FIFO control strobe.

Character transfers are handed to the datapath as single-cycle strobes. A transmit push carries the written byte. A receive pop marks a character as consumed.

Top module: `sio_reg_decoder`

## Requirements
- R1: Acknowledge `bus_ack` is high for exactly one clock, on the clock edge after `bus_cyc` and `bus_stb` are first seen high together without a pending acknowledge. It is never high on two consecutive clocks, so a held request is acknowledged every other clock.
- R2: After reset the line control, interrupt enable, modem control and divisor outputs are all zero. `bus_ack` and all strobes are low.
- R3: Offset 3 reads and writes the line control register whatever its bit 7 holds. Bit 7 is the bank-select bit, and a write to it takes effect from the next access.
- R4: With bit 7 clear, a write to offset 0 gives a one-clock `tx_push` with the written byte on `wr_byte`. A read of offset 0 returns `rx_char` and gives a one-clock `rx_pop`.
- R5: With bit 7 clear, offset 1 reads and writes the interrupt enable register.
- R6: With bit 7 set, offset 0 reads and writes divisor bits [7:0] and offset 1 reads and writes divisor bits [15:8]. Neither offset makes a push or pop strobe, and the interrupt enable register is left untouched.
- R7: Regardless of bit 7, a read of offset 2 returns `int_ident`, and a write to offset 2 gives a one-clock `fcr_wr` with the written byte on `wr_byte`.
- R8: A write to offset 4 loads the modem control register. A read of offset 4 returns 0x00.
- R9: Reads of offsets 5 and 6 return `line_stat` and `modem_stat`. A read of offset 7 returns 0x00. Writes to offsets 5, 6 and 7 change no register and make no strobe.
- R10: `tx_push`, `rx_pop` and `fcr_wr` are each high for one clock only, never together, and only in a clock where `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 3 | Register offset |
| bus_wdat | input | 8 | Write data |
| bus_rdat | output | 8 | Read data, valid while `bus_ack` is high on a read |
| bus_ack | output | 1 | Transfer acknowledge |
| rx_char | input | 8 | Character at the head of the receive queue |
| int_ident | input | 8 | Interrupt identification value |
| line_stat | input | 8 | Line status value |
| modem_stat | input | 8 | Modem status value |
| lcr_q | output | 8 | Line control register |
| ier_q | output | 8 | Interrupt enable register |
| mcr_q | output | 8 | Modem control register |
| div_q | output | 16 | Baud divisor |
| tx_push | output | 1 | One-clock transmit push strobe |
| rx_pop | output | 1 | One-clock receive pop strobe |
| fcr_wr | output | 1 | One-clock FIFO control write strobe |
| wr_byte | output | 8 | Byte carried by `tx_push` or `fcr_wr` |

## Verification
The bench goes after the banked offsets in both states of the bank bit.

A decoder that ignored the bank bit would push the low divisor byte into the transmit path, or pop a receive character on a divisor read. It would also overwrite the interrupt enable register when the high divisor byte is written. These faults show up as unexpected strobes, or as a stale interrupt enable value once the bank bit is cleared again.

The bench holds a request for several clocks to catch an acknowledge that stays high or repeats back-to-back. It writes to the read-only and unused offsets to catch a decoder that lets those writes alias into a register. It reads the write-only offsets, which must return zero rather than a stored value.

// File: rtl/sio_reg_pkg.sv
package sio_reg_pkg;
  localparam int OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_FIFO  = 3'd2,
    OFS_LINE  = 3'd3,
    OFS_MODEM = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SPARE = 3'd7
  } reg_ofs_e;
endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sio_bus_handshake.sv
module sio_bus_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc,
  input  logic stb,
  output logic ack,
  output logic take
);
  logic ack_d;

  always_comb begin
    take  = cyc & stb & ~ack;
    ack_d = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= ack_d;
  end

  // R1: acknowledge never on two consecutive clocks
  p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R1: a fresh request is acknowledged on the next edge
  p_ack_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack) |=> ack);
endmodule

// File: rtl/sio_reg_store.sv
module sio_reg_store
  import sio_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              we,
  input  reg_ofs_e          ofs,
  input  logic [DATA_W-1:0] wdat,
  output logic [DATA_W-1:0] lcr_q,
  output logic [DATA_W-1:0] ier_q,
  output logic [DATA_W-1:0] mcr_q,
  output logic [2*DATA_W-1:0] div_q,
  output logic              tx_push,
  output logic              rx_pop,
  output logic              fcr_wr,
  output logic [DATA_W-1:0] wr_byte
);
  localparam int BANK_BIT = DATA_W - 1;

  logic bank;
  logic wr_go, rd_go;
  logic lcr_en, ier_en, mcr_en, dlo_en, dhi_en, byte_en;
  logic push_d, pop_d, fcr_d;

  assign bank  = lcr_q[BANK_BIT];
  assign wr_go = take & we;
  assign rd_go = take & ~we;

  // next-state decode
  always_comb begin
    lcr_en  = 1'b0;
    ier_en  = 1'b0;
    mcr_en  = 1'b0;
    dlo_en  = 1'b0;
    dhi_en  = 1'b0;
    push_d  = 1'b0;
    pop_d   = 1'b0;
    fcr_d   = 1'b0;
    unique case (ofs)
      OFS_DATA: begin
        if (bank) dlo_en = wr_go;
        else begin
          push_d = wr_go;
          pop_d  = rd_go;
        end
      end
      OFS_IEN: begin
        if (bank) dhi_en = wr_go;
        else      ier_en = wr_go;
      end
      OFS_FIFO:  fcr_d  = wr_go;
      OFS_LINE:  lcr_en = wr_go;
      OFS_MODEM: mcr_en = wr_go;
      default: ;
    endcase
    byte_en = push_d | fcr_d;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lcr_q <= '0;
    else if (lcr_en) lcr_q <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else if (ier_en) ier_q <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcr_q <= '0;
    else if (mcr_en) mcr_q <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q[DATA_W-1:0] <= '0;
    else if (dlo_en) div_q[DATA_W-1:0] <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q[2*DATA_W-1:DATA_W] <= '0;
    else if (dhi_en) div_q[2*DATA_W-1:DATA_W] <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_byte <= '0;
    else if (byte_en) wr_byte <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_push <= 1'b0;
      rx_pop  <= 1'b0;
      fcr_wr  <= 1'b0;
    end else begin
      tx_push <= push_d;
      rx_pop  <= pop_d;
      fcr_wr  <= fcr_d;
    end
  end

  // R3: line control changes only after a write to offset 3
  p_lcr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && we && ofs == OFS_LINE) |=> $stable(lcr_q));
  // R4: a push follows only a bank-0 write of offset 0
  p_push_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(take && we && ofs == OFS_DATA && !bank));
  // R4: a pop follows only a bank-0 read of offset 0
  p_pop_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(take && !we && ofs == OFS_DATA && !bank));
  // R6: divisor cannot move while the bank bit was clear
  p_div_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bank |=> $stable(div_q));
  // R10: at most one strobe at a time
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_push, rx_pop, fcr_wr}));
endmodule

// File: rtl/sio_read_sel.sv
module sio_read_sel
  import sio_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                we,
  input  reg_ofs_e            ofs,
  input  logic [DATA_W-1:0]   lcr_q,
  input  logic [DATA_W-1:0]   ier_q,
  input  logic [2*DATA_W-1:0] div_q,
  input  logic [DATA_W-1:0]   rx_char,
  input  logic [DATA_W-1:0]   int_ident,
  input  logic [DATA_W-1:0]   line_stat,
  input  logic [DATA_W-1:0]   modem_stat,
  output logic [DATA_W-1:0]   rdat
);
  localparam int BANK_BIT = DATA_W - 1;

  logic              bank;
  logic              rd_en;
  logic [DATA_W-1:0] rdat_d;

  assign bank  = lcr_q[BANK_BIT];
  assign rd_en = take & ~we;

  always_comb begin
    unique case (ofs)
      OFS_DATA:  rdat_d = bank ? div_q[DATA_W-1:0] : rx_char;
      OFS_IEN:   rdat_d = bank ? div_q[2*DATA_W-1:DATA_W] : ier_q;
      OFS_FIFO:  rdat_d = int_ident;
      OFS_LINE:  rdat_d = lcr_q;
      OFS_LSTAT: rdat_d = line_stat;
      OFS_MSTAT: rdat_d = modem_stat;
      default:   rdat_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdat <= '0;
    else if (rd_en) rdat <= rdat_d;
  end
endmodule

// File: rtl/sio_reg_decoder.sv
module sio_reg_decoder
  import sio_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_cyc,
  input  logic                bus_stb,
  input  logic                bus_we,
  input  logic [OFS_W-1:0]    bus_adr,
  input  logic [DATA_W-1:0]   bus_wdat,
  output logic [DATA_W-1:0]   bus_rdat,
  output logic                bus_ack,
  input  logic [DATA_W-1:0]   rx_char,
  input  logic [DATA_W-1:0]   int_ident,
  input  logic [DATA_W-1:0]   line_stat,
  input  logic [DATA_W-1:0]   modem_stat,
  output logic [DATA_W-1:0]   lcr_q,
  output logic [DATA_W-1:0]   ier_q,
  output logic [DATA_W-1:0]   mcr_q,
  output logic [2*DATA_W-1:0] div_q,
  output logic                tx_push,
  output logic                rx_pop,
  output logic                fcr_wr,
  output logic [DATA_W-1:0]   wr_byte
);
  logic     rst_sync_n;
  logic     take;
  reg_ofs_e ofs;

  assign ofs = reg_ofs_e'(bus_adr);

  sio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sio_bus_handshake u_hs (
    .clk(clk), .rst_n(rst_sync_n), .cyc(bus_cyc), .stb(bus_stb),
    .ack(bus_ack), .take(take)
  );

  sio_reg_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .take(take), .we(bus_we), .ofs(ofs),
    .wdat(bus_wdat), .lcr_q(lcr_q), .ier_q(ier_q), .mcr_q(mcr_q),
    .div_q(div_q), .tx_push(tx_push), .rx_pop(rx_pop), .fcr_wr(fcr_wr),
    .wr_byte(wr_byte)
  );

  sio_read_sel #(.DATA_W(DATA_W)) u_rsel (
    .clk(clk), .rst_n(rst_sync_n), .take(take), .we(bus_we), .ofs(ofs),
    .lcr_q(lcr_q), .ier_q(ier_q), .div_q(div_q), .rx_char(rx_char),
    .int_ident(int_ident), .line_stat(line_stat), .modem_stat(modem_stat),
    .rdat(bus_rdat)
  );

  // R10: every strobe coincides with the acknowledge
  p_strobe_ack_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_push || rx_pop || fcr_wr) |-> bus_ack);
endmodule

// File: tb/sio_reg_decoder_test.sv
module sio_reg_decoder_test;
  localparam int NV = 26;
  localparam logic [7:0] RXC = 8'hA5, IID = 8'hC1, LST = 8'h60, MST = 8'hB0;
  // {we, adr[2:0], data/expected[7:0], push, pop, fcr}
  localparam logic [14:0] VEC [NV] = '{
    {1'b0,3'd3,8'h00,3'b000}, {1'b0,3'd1,8'h00,3'b000},
    {1'b1,3'd1,8'h0F,3'b000}, {1'b0,3'd1,8'h0F,3'b000},
    {1'b1,3'd0,8'h5A,3'b100}, {1'b0,3'd0,RXC,  3'b010},
    {1'b1,3'd2,8'hC7,3'b001}, {1'b0,3'd2,IID,  3'b000},
    {1'b1,3'd3,8'h83,3'b000}, {1'b0,3'd3,8'h83,3'b000},
    {1'b1,3'd0,8'h34,3'b000}, {1'b1,3'd1,8'h12,3'b000},
    {1'b0,3'd0,8'h34,3'b000}, {1'b0,3'd1,8'h12,3'b000},
    {1'b1,3'd2,8'h06,3'b001}, {1'b1,3'd3,8'h03,3'b000},
    {1'b0,3'd1,8'h0F,3'b000}, {1'b0,3'd0,RXC,  3'b010},
    {1'b1,3'd4,8'h1B,3'b000}, {1'b0,3'd4,8'h00,3'b000},
    {1'b0,3'd5,LST,  3'b000}, {1'b0,3'd6,MST,  3'b000},
    {1'b0,3'd7,8'h00,3'b000}, {1'b1,3'd5,8'hFF,3'b000},
    {1'b1,3'd6,8'hFF,3'b000}, {1'b1,3'd7,8'hFF,3'b000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cyc = 0, bus_stb = 0, bus_we = 0;
  logic [2:0] bus_adr = '0;
  logic [7:0] bus_wdat = '0, bus_rdat, lcr_q, ier_q, mcr_q, wr_byte;
  logic [15:0] div_q;
  logic bus_ack, tx_push, rx_pop, fcr_wr;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sio_reg_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdat(bus_wdat),
    .bus_rdat(bus_rdat), .bus_ack(bus_ack), .rx_char(RXC),
    .int_ident(IID), .line_stat(LST), .modem_stat(MST), .lcr_q(lcr_q),
    .ier_q(ier_q), .mcr_q(mcr_q), .div_q(div_q), .tx_push(tx_push),
    .rx_pop(rx_pop), .fcr_wr(fcr_wr), .wr_byte(wr_byte)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access; returns values seen in the acknowledge clock
  task automatic access(input logic we, input logic [2:0] adr,
                        input logic [7:0] d, output logic [7:0] rd,
                        output logic [2:0] strb, output logic [7:0] byt);
    int waits = 0;
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = adr; bus_wdat = d;
    do begin
      @(negedge clk);
      waits++;
    end while (!bus_ack && waits < 5);
    chk(bus_ack == 1'b1 && waits == 1, "R1 ack latency", waits, 1);
    rd = bus_rdat; strb = {tx_push, rx_pop, fcr_wr}; byt = wr_byte;
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
    @(negedge clk);
    chk({bus_ack, tx_push, rx_pop, fcr_wr} == 4'b0, "R10 strobes one clock",
        {bus_ack, tx_push, rx_pop, fcr_wr}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd, byt;
    logic [2:0] strb;
    logic [5:0] ackpat;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2 reset state
    chk({lcr_q, ier_q, mcr_q} == 24'h0, "R2 reset regs", {lcr_q, ier_q, mcr_q}, 0);
    chk(div_q == 16'h0, "R2 reset divisor", div_q, 0);
    chk({bus_ack, tx_push, rx_pop, fcr_wr} == 4'b0, "R2 reset strobes",
        {bus_ack, tx_push, rx_pop, fcr_wr}, 0);

    // vector walk: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      access(v[14], v[13:11], v[10:3], rd, strb, byt);
      if (!v[14])
        chk(rd == v[10:3], $sformatf("R3-R9 read vec %0d", i), rd, v[10:3]);
      chk(strb == v[2:0], $sformatf("R4/R6/R7/R9 strobes vec %0d", i), strb, v[2:0]);
      if (v[2] || v[0])
        chk(byt == v[10:3], $sformatf("R4/R7 byte vec %0d", i), byt, v[10:3]);
    end

    // R6 divisor landed, R8 modem control, R9 ignored writes left regs alone
    chk(div_q == 16'h1234, "R6 divisor port", div_q, 16'h1234);
    chk(mcr_q == 8'h1B, "R8 modem control", mcr_q, 8'h1B);
    chk(ier_q == 8'h0F, "R6 ier untouched by divisor bank", ier_q, 8'h0F);
    chk(lcr_q == 8'h03, "R9 lcr after ignored writes", lcr_q, 8'h03);

    // R1 held request: ack every other clock
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = 3'd5;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      ackpat[k] = bus_ack;
    end
    bus_cyc = 0; bus_stb = 0;
    chk(ackpat == 6'b010101, "R1 held strobe ack pattern", ackpat, 6'b010101);
    // R1 cyc without stb gives nothing
    bus_cyc = 1;
    @(negedge clk); @(negedge clk);
    chk(bus_ack == 1'b0, "R1 no ack without strobe", bus_ack, 0);
    bus_cyc = 0;

    // R2 reset mid-run clears registers
    rst_n = 1'b0;
    #1;
    chk({lcr_q, ier_q, mcr_q} == 24'h0 && div_q == 16'h0, "R2 reset mid-run",
        {lcr_q, ier_q, mcr_q, div_q}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b0, 3'd1, 8'h00, rd, strb, byt);
    chk(rd == 8'h00, "R5 ier read after reset", rd, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule